// File: doc/BRIEF.md
# Two-Word Compressed Cache Line Decompressor

This block turns the variable-length bitstream of one compressed 64-byte cache line back into sixteen 32-bit words. Compressed data arrives in 128-bit beats and is packed most-significant bit first. Each cycle the block takes two codewords from the front of an alignment window, rebuilds both words, and adds every word that is not one of the zero patterns to a 16-entry FIFO dictionary. This keeps the dictionary identical to the one the compressor built. The second word of a pair may refer to the dictionary slot that the first word of the same pair is filling.

The window holds up to 196 bits. When fewer than 68 bits are buffered (two worst-case codewords) and the line's final beat has not yet arrived, the next input beat is appended behind the leftover bits. Decoding then pauses for that cycle. Every four rebuilt words leave at once as a 128-bit output beat. The fourth beat of a line carries an end flag. A line whose first beat is flagged raw skips decoding and is copied to the output beat by beat.

Top module: `cpk_line_unpack`

## Requirements
- R1: After reset, `out_valid` and `out_last` are 0 and `in_ready` is 1.
- R2: Each codeword decodes by its leading bits, with an index field of 4 bits. `00` gives an all-zero word in 2 bits. `01` is followed by a 32-bit literal (34 bits). `10` is followed by an index, and the word is that dictionary entry (6 bits). `1100` is followed by an index and a 16-bit literal, giving entry[31:16] joined to the literal (24 bits). `1101` is followed by an 8-bit literal, giving 24 zero bits and then the literal (12 bits). `1110` is followed by an index and an 8-bit literal, giving entry[31:8] joined to the literal (16 bits).
- R3: Words decoded by codes `01`, `10`, `1100` and `1110` are written to dictionary slots 0, 1, 2 … in decode order. Words decoded by `00` and `1101` are not written.
- R4: When the second word of a pair names the slot that the first word of the same pair is written to, it uses the first word's value.
- R5: All dictionary slots read as zero at the start of every compressed line, whatever earlier lines stored.
- R6: With fewer than 68 bits buffered and the final beat not yet taken, `in_ready` is 1 and no decoding takes place. An accepted beat is appended after the leftover bits, so codewords that straddle two beats decode correctly.
- R7: Words 4k to 4k+3 of a line form output beat k, with word 4k in bits [127:96]. The beat is sent as soon as those four words are rebuilt, and each line produces exactly four beats.
- R8: `out_last` is 1 only on the fourth output beat of a line.
- R9: When `in_raw` is set on the first beat of a line, that beat and the next three accepted beats appear unchanged on `out_data` one cycle after they are accepted, in order, with `out_last` on the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat is taken this cycle when `in_valid` is also 1 |
| in_data | input | 128 | Input beat, first stream bit in bit 127 |
| in_raw | input | 1 | On the first beat of a line: the line is uncompressed |
| in_last | input | 1 | Final beat of a compressed line's stream |
| out_valid | output | 1 | Output beat present for one cycle |
| out_data | output | 128 | Four rebuilt words, first word in bits [127:96] |
| out_last | output | 1 | Fourth and final output beat of a line |

## Verification
The dictionary write of a pair's first word and the dictionary read of its second word happen in the same cycle. This matters whenever two identical or near-identical words sit at an even/odd position pair. The bench provokes it with lines whose words repeat in pairs, and with a swept mix of repeated, partly matching, zero and literal words. Its own bit-level compressor model produces the streams, so the second word of a pair regularly names the slot being filled in that same cycle. A line is judged correct only if every output beat equals the original words packed four to a beat. A stale or missing forward would corrupt the second word of the pair and every later word that copies it.

// File: rtl/cpk_pkg.sv
`timescale 1ns/1ps
// Shared sizes, word kinds and word rebuild helpers for the line decompressor.
// Assumes a 4-bit dictionary index embedded in the codeword format.
package cpk_pkg;
    localparam int WORD_W         = 32;
    localparam int BEAT_W         = 128;
    localparam int WORDS_PER_LINE = 16;
    localparam int WORDS_PER_BEAT = BEAT_W / WORD_W;
    localparam int BEATS_PER_LINE = WORDS_PER_LINE / WORDS_PER_BEAT;
    localparam int DICT_N         = 16;
    localparam int IDX_W          = $clog2(DICT_N);
    localparam int MAX_CW         = 2 + WORD_W;
    localparam int PAIR_BITS      = 2 * MAX_CW;
    localparam int BUF_W          = PAIR_BITS + BEAT_W;
    localparam int CNT_W          = $clog2(BUF_W + 1);
    localparam int LEN_W          = $clog2(MAX_CW + 1);

    localparam logic [LEN_W-1:0] L_ZERO = LEN_W'(2);
    localparam logic [LEN_W-1:0] L_RAW  = LEN_W'(MAX_CW);
    localparam logic [LEN_W-1:0] L_FULL = LEN_W'(2 + IDX_W);
    localparam logic [LEN_W-1:0] L_HALF = LEN_W'(4 + IDX_W + WORD_W/2);
    localparam logic [LEN_W-1:0] L_LOWB = LEN_W'(4 + WORD_W/4);
    localparam logic [LEN_W-1:0] L_TRIP = LEN_W'(4 + IDX_W + WORD_W/4);
    localparam logic [LEN_W-1:0] L_RSVD = LEN_W'(4);

    typedef enum logic [2:0] {
        K_ZERO, K_RAW, K_FULL, K_HALF, K_LOWB, K_TRIP, K_RSVD
    } kind_t;

    // Combine zero bytes, dictionary bytes and literal bytes for one word.
    function automatic logic [WORD_W-1:0] rebuild(input kind_t k,
                                                  input logic [WORD_W-1:0] d,
                                                  input logic [WORD_W-1:0] lit);
        unique case (k)
            K_RAW, K_LOWB: return lit;
            K_FULL:        return d;
            K_HALF:        return {d[WORD_W-1:WORD_W/2], lit[WORD_W/2-1:0]};
            K_TRIP:        return {d[WORD_W-1:WORD_W/4], lit[WORD_W/4-1:0]};
            default:       return '0;
        endcase
    endfunction

    // Word kinds that enter the dictionary (all but the zero patterns).
    function automatic logic pushes(input kind_t k);
        return (k == K_RAW) || (k == K_FULL) || (k == K_HALF) || (k == K_TRIP);
    endfunction
endpackage

// File: rtl/cpk_word_dec.sv
`timescale 1ns/1ps
// Decodes one codeword at the top of a MAX_CW-bit window into kind, length,
// dictionary index and right-aligned literal. Assumes the window is MSB-first.
// The reserved code 1111 is read as a 4-bit zero word that is not pushed.
module cpk_word_dec
    import cpk_pkg::*;
(
    input  logic [MAX_CW-1:0] bits,
    output kind_t             kind,
    output logic [LEN_W-1:0]  len,
    output logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] lit
);
    localparam int T = MAX_CW - 1;

    // Classify by the 2-bit prefix, then by the 2-bit suffix for long codes.
    always_comb begin
        kind = K_ZERO;
        len  = L_ZERO;
        idx  = '0;
        lit  = '0;
        unique case (bits[T -: 2])
            2'b00: ;
            2'b01: begin
                kind = K_RAW;  len = L_RAW;
                lit  = bits[T-2 -: WORD_W];
            end
            2'b10: begin
                kind = K_FULL; len = L_FULL;
                idx  = bits[T-2 -: IDX_W];
            end
            default: begin
                unique case (bits[T-2 -: 2])
                    2'b00: begin
                        kind = K_HALF; len = L_HALF;
                        idx  = bits[T-4 -: IDX_W];
                        lit[WORD_W/2-1:0] = bits[T-4-IDX_W -: WORD_W/2];
                    end
                    2'b01: begin
                        kind = K_LOWB; len = L_LOWB;
                        lit[WORD_W/4-1:0] = bits[T-4 -: WORD_W/4];
                    end
                    2'b10: begin
                        kind = K_TRIP; len = L_TRIP;
                        idx  = bits[T-4 -: IDX_W];
                        lit[WORD_W/4-1:0] = bits[T-4-IDX_W -: WORD_W/4];
                    end
                    default: begin
                        kind = K_RSVD; len = L_RSVD;
                    end
                endcase
            end
        endcase
    end
endmodule

// File: rtl/cpk_dict.sv
`timescale 1ns/1ps
// FIFO dictionary: up to two pushes per cycle into consecutive slots, two
// read ports. Read port 1 sees the value push 0 is writing in the same cycle.
// Assumes pushes are already gated by the decode enable.
module cpk_dict
    import cpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push0,
    input  logic [WORD_W-1:0] data0,
    input  logic              push1,
    input  logic [WORD_W-1:0] data1,
    input  logic [IDX_W-1:0]  idx0,
    input  logic [IDX_W-1:0]  idx1,
    output logic [WORD_W-1:0] rd0,
    output logic [WORD_W-1:0] rd1
);
    logic [WORD_W-1:0] ents [DICT_N];
    logic [IDX_W-1:0]  wptr_q;

    // Read ports, with same-cycle forwarding of the first push.
    always_comb begin
        rd0 = ents[idx0];
        rd1 = (push0 && (idx1 == wptr_q)) ? data0 : ents[idx1];
    end

    // Clear per line, else write pushes at the pointer and advance it.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < DICT_N; i++) ents[i] <= '0;
            wptr_q <= '0;
        end else begin
            if (push0) ents[wptr_q] <= data0;
            if (push1) ents[wptr_q + IDX_W'(push0)] <= data1;
            wptr_q <= wptr_q + IDX_W'(push0) + IDX_W'(push1);
        end
    end

    // R3
    wptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (wptr_q == $past(wptr_q) + IDX_W'($past(push0)) + IDX_W'($past(push1))));
    // R5
    wptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (wptr_q == '0));
endmodule

// File: rtl/cpk_line_unpack.sv
`timescale 1ns/1ps
// Line decompressor top: alignment window with refill below two worst-case
// codewords, two word decoders per cycle, FIFO dictionary, four-word output
// beats, raw pass-through. Assumes a well-formed stream per line and in_last
// on the line's final compressed beat.
module cpk_line_unpack
    import cpk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BEAT_W-1:0] in_data,
    input  logic              in_raw,
    input  logic              in_last,
    output logic              out_valid,
    output logic [BEAT_W-1:0] out_data,
    output logic              out_last
);
    localparam int NPAIRS  = WORDS_PER_LINE / 2;
    localparam int PAIR_CW = $clog2(NPAIRS);
    localparam int PPB     = WORDS_PER_BEAT / 2;
    localparam int PB_W    = $clog2(PPB);
    localparam int RAW_CW  = $clog2(BEATS_PER_LINE);
    localparam int ACC_W   = BEAT_W - 2*WORD_W;

    typedef enum logic [1:0] {S_IDLE, S_RAW, S_DEC} st_t;

    st_t                st_q;
    logic [BUF_W-1:0]   buf_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               tail_q;
    logic [PAIR_CW-1:0] pair_q;
    logic [RAW_CW-1:0]  raw_q;
    logic [ACC_W-1:0]   acc_q;

    kind_t             k0, k1;
    logic [LEN_W-1:0]  len0, len1;
    logic [IDX_W-1:0]  idx0, idx1;
    logic [WORD_W-1:0] lit0, lit1, rd0, rd1, word0, word1;
    logic [BUF_W-1:0]  sh1;
    logic [CNT_W-1:0]  used;
    logic              dec_en, push0, push1, clr, beat_end, line_end;

    // Window views for the two codewords and the decode/refill conditions.
    always_comb begin
        sh1      = buf_q << len0;
        used     = CNT_W'(len0) + CNT_W'(len1);
        dec_en   = (st_q == S_DEC) && ((cnt_q >= CNT_W'(PAIR_BITS)) || tail_q);
        in_ready = (st_q != S_DEC) || (!tail_q && (cnt_q < CNT_W'(PAIR_BITS)));
        clr      = (st_q == S_IDLE) && in_valid && !in_raw;
        word0    = rebuild(k0, rd0, lit0);
        word1    = rebuild(k1, rd1, lit1);
        push0    = dec_en && pushes(k0);
        push1    = dec_en && pushes(k1);
        beat_end = (pair_q[PB_W-1:0] == PB_W'(PPB - 1));
        line_end = (pair_q == PAIR_CW'(NPAIRS - 1));
    end

    cpk_word_dec i_dec0 (.bits(buf_q[BUF_W-1 -: MAX_CW]), .kind(k0), .len(len0), .idx(idx0), .lit(lit0));
    cpk_word_dec i_dec1 (.bits(sh1[BUF_W-1 -: MAX_CW]),   .kind(k1), .len(len1), .idx(idx1), .lit(lit1));

    cpk_dict i_dict (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .push0(push0), .data0(word0), .push1(push1), .data1(word1),
        .idx0(idx0), .idx1(idx1), .rd0(rd0), .rd1(rd1)
    );

    // Line sequencing, window shift/refill and output beat assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= S_IDLE;
            buf_q     <= '0;
            cnt_q     <= '0;
            tail_q    <= 1'b0;
            pair_q    <= '0;
            raw_q     <= '0;
            acc_q     <= '0;
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            unique case (st_q)
                S_IDLE: if (in_valid) begin
                    if (in_raw) begin
                        out_valid <= 1'b1;
                        out_data  <= in_data;
                        raw_q     <= RAW_CW'(1);
                        st_q      <= S_RAW;
                    end else begin
                        buf_q  <= {in_data, {PAIR_BITS{1'b0}}};
                        cnt_q  <= CNT_W'(BEAT_W);
                        tail_q <= in_last;
                        pair_q <= '0;
                        st_q   <= S_DEC;
                    end
                end
                S_RAW: if (in_valid) begin
                    out_valid <= 1'b1;
                    out_data  <= in_data;
                    raw_q     <= raw_q + RAW_CW'(1);
                    if (raw_q == RAW_CW'(BEATS_PER_LINE - 1)) begin
                        out_last <= 1'b1;
                        st_q     <= S_IDLE;
                    end
                end
                S_DEC: if (dec_en) begin
                    buf_q  <= buf_q << used;
                    cnt_q  <= cnt_q - used;
                    acc_q  <= ACC_W'({acc_q, word0, word1});
                    pair_q <= pair_q + PAIR_CW'(1);
                    if (beat_end) begin
                        out_valid <= 1'b1;
                        out_data  <= {acc_q, word0, word1};
                        out_last  <= line_end;
                    end
                    if (line_end) st_q <= S_IDLE;
                end else if (in_valid) begin
                    buf_q  <= buf_q | ({in_data, {PAIR_BITS{1'b0}}} >> cnt_q);
                    cnt_q  <= cnt_q + CNT_W'(BEAT_W);
                    tail_q <= in_last;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // R6
    refill_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_en |-> !in_ready);
    // R6
    window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(BUF_W));
    // R8
    last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
    // R9
    raw_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_RAW && in_valid) |=> (out_valid && out_data == $past(in_data)));
endmodule

// File: tb/test_cpk_line_unpack.sv
`timescale 1ns/1ps
// Bench: a bit-level compressor model builds each line's stream; the design's
// output beats are compared with the original words.
module test_cpk_line_unpack;
    localparam int SMAX = 640;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0, in_raw = 1'b0, in_last = 1'b0;
    logic [127:0] in_data = '0;
    logic         in_ready, out_valid, out_last;
    logic [127:0] out_data;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [31:0]     line_w [16];
    logic [SMAX-1:0] sb;
    int              sp;
    logic [31:0]     lcg = 32'h1234_5678;

    always #4 clk = ~clk;

    cpk_line_unpack i_cpk_line_unpack (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_raw(in_raw), .in_last(in_last),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: run incomplete, got %0d cycles, expected fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic put(input logic [63:0] v, input int n);
        for (int i = 0; i < n; i++) sb[SMAX-1-sp-i] = v[n-1-i];
        sp += n;
    endtask

    // Reference compressor: zero patterns, best dictionary match, else literal.
    task automatic compress_line();
        logic [31:0] d [16];
        int nd, best, bidx, m;
        logic [31:0] w;
        sb = '0; sp = 0; nd = 0;
        for (int i = 0; i < 16; i++) begin
            w = line_w[i];
            if (w == 0) put(64'd0, 2);
            else if (w[31:8] == 0) put({52'd0, 4'b1101, w[7:0]}, 12);
            else begin
                best = 0; bidx = 0;
                for (int s = 0; s < nd; s++) begin
                    if (d[s] == w) m = 4;
                    else if (d[s][31:8] == w[31:8]) m = 3;
                    else if (d[s][31:16] == w[31:16]) m = 2;
                    else m = 0;
                    if (m > best) begin best = m; bidx = s; end
                end
                case (best)
                    4: put({58'd0, 2'b10, bidx[3:0]}, 6);
                    3: put({48'd0, 4'b1110, bidx[3:0], w[7:0]}, 16);
                    2: put({40'd0, 4'b1100, bidx[3:0], w[15:0]}, 24);
                    default: put({30'd0, 2'b01, w}, 34);
                endcase
                d[nd] = w; nd++;
            end
        end
    endtask

    task automatic send_beat(input logic [127:0] data, input logic raw, input logic last);
        logic acc;
        in_valid = 1'b1; in_data = data; in_raw = raw; in_last = last;
        do begin
            acc = in_ready;
            @(posedge clk); #1;
        end while (!acc);
        in_valid = 1'b0; in_raw = 1'b0; in_last = 1'b0;
    endtask

    task automatic drive(input bit raw);
        int nb;
        if (raw) begin
            for (int k = 0; k < 4; k++)
                send_beat({line_w[4*k], line_w[4*k+1], line_w[4*k+2], line_w[4*k+3]}, k == 0, k == 3);
        end else begin
            nb = (sp + 127) / 128;
            for (int k = 0; k < nb; k++)
                send_beat(sb[SMAX-1-128*k -: 128], 1'b0, k == nb - 1);
        end
    endtask

    // Collect four output beats; check packing (R7) and end flag (R8).
    task automatic collect(input string tag);
        int got = 0, idle = 0;
        while (got < 4 && idle < 2000) begin
            @(negedge clk);
            if (out_valid) begin
                chk(tag, out_data, {line_w[4*got], line_w[4*got+1], line_w[4*got+2], line_w[4*got+3]});
                chk("R8 end flag", {127'd0, out_last}, {127'd0, (got == 3)});
                got++;
            end else idle++;
        end
        if (got < 4) chk("R7 beat count", 128'(got), 128'd4);
    endtask

    task automatic run_line(input string tag, input bit raw, input bit prebuilt);
        if (!raw && !prebuilt) compress_line();
        fork
            drive(raw);
            collect(tag);
        join
    endtask

    function automatic logic [31:0] next_rand();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return lcg;
    endfunction

    initial begin
        logic [31:0] r, a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 out_valid", {127'd0, out_valid}, 128'd0);
        chk("R1 out_last", {127'd0, out_last}, 128'd0);
        chk("R1 in_ready", {127'd0, in_ready}, 128'd1);

        // R2 all-zero line
        for (int i = 0; i < 16; i++) line_w[i] = 32'd0;
        run_line("R2 zero line", 1'b0, 1'b0);

        // R6 literal-heavy line: codewords straddle beat boundaries
        for (int i = 0; i < 16; i++) line_w[i] = 32'h9E37_79B9 * (i + 1) ^ 32'h8000_0001;
        run_line("R6 spanning line", 1'b0, 1'b0);

        // R2 / R3 every code class
        a = 32'hCAFE_D00D;
        line_w[0] = a;               line_w[1] = 32'h0000_005A;
        line_w[2] = a;               line_w[3] = a ^ 32'h0000_0011;
        line_w[4] = a ^ 32'h0000_1234; line_w[5] = 32'd0;
        line_w[6] = 32'h1357_9BDF;   line_w[7] = 32'h1357_9B00;
        line_w[8] = 32'h1357_0000;   line_w[9] = 32'h0000_00FF;
        line_w[10] = 32'h1357_9BDF;  line_w[11] = a ^ 32'h0000_0011;
        line_w[12] = 32'hFFFF_FFFF;  line_w[13] = 32'hFFFF_0001;
        line_w[14] = 32'd0;          line_w[15] = 32'hCAFE_0000;
        run_line("R2 R3 code classes", 1'b0, 1'b0);

        // R4 each pair's second word copies its first word
        for (int k = 0; k < 8; k++) begin
            line_w[2*k]   = 32'h4100_0000 + 32'h0101_0303 * (k + 1);
            line_w[2*k+1] = (k % 2 == 0) ? line_w[2*k] : (line_w[2*k] ^ 32'h0000_0077);
        end
        run_line("R4 same-cycle forward", 1'b0, 1'b0);

        // R5 stale-slot reference right after a populated line reads zero
        for (int i = 0; i < 16; i++) line_w[i] = 32'd0;
        sb = '0; sp = 0;
        for (int i = 0; i < 16; i++) put({58'd0, 2'b10, 4'd5}, 6);
        run_line("R5 cleared dictionary", 1'b0, 1'b1);

        // R9 raw line, then compressed line directly after
        for (int i = 0; i < 16; i++) line_w[i] = 32'h0000_0000 + 32'h1111_1111 * i;
        run_line("R9 raw pass", 1'b1, 1'b0);

        // R2 R3 R4 R6 R7 sweep over mixed word classes, raw lines interleaved
        for (int ln = 0; ln < 60; ln++) begin
            for (int i = 0; i < 16; i++) begin
                r = next_rand();
                case (r[2:0])
                    3'd0: line_w[i] = 32'd0;
                    3'd1: line_w[i] = {24'd0, r[15:8]};
                    3'd2: line_w[i] = (i > 0) ? line_w[i-1] : r;
                    3'd3: line_w[i] = (i > 1) ? {line_w[i-2][31:8], r[15:8]} : r;
                    3'd4: line_w[i] = (i > 2) ? {line_w[i-3][31:16], r[23:8]} : r;
                    default: line_w[i] = next_rand() | 32'h0100_0000;
                endcase
            end
            run_line((ln % 7 == 6) ? "R9 sweep raw" : "R7 sweep line", (ln % 7 == 6), 1'b0);
        end

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule